// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block holds the approximation register and the sequencing logic of a successive approximation converter. A start request launches a conversion. The block then tests one bit per clock, from the most significant bit down to the least significant bit. Each trial code drives an external DAC. An external comparator reports whether the DAC level is above the sampled input.

If the DAC level is above the input, the bit under test is dropped. Otherwise it is kept, so a DAC level equal to the input also keeps the bit. The decided upper bits are held while the next lower bit is tried. The conversion length is fixed at one cycle per bit, whatever the input.

When the last decision lands, the final code is written to a result register. A single-cycle completion pulse marks that update. The result holds until the next conversion completes. The analog parts, sample-and-hold sequencing and calibration lie outside this block.

Top module: `sar_approx_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `trial_code` and `result` are all zero.
- R2: A `start` sampled high while idle makes `busy` high at the next edge, with `trial_code` holding only the MSB set (8'h80 for WIDTH=8).
- R3: When `cmp_hi` is 1 (DAC level above the input) at the edge that ends a bit cycle, the bit under test is cleared.
- R4: When `cmp_hi` is 0 at that edge, including the case where the DAC level equals the input, the bit under test stays 1.
- R5: At each decision edge the next lower bit is set as the new trial, and all already decided higher bits keep their value.
- R6: `busy` stays high for exactly WIDTH cycles per conversion, for every input value.
- R7: `done` is high for exactly one cycle. `result` takes the final code at the same edge, and `busy` falls at that edge.
- R8: A `start` sampled while `busy` is high is ignored. The running conversion keeps its trial sequence and its length.
- R9: `result` changes only at edges where `done` rises and otherwise holds its value.
- R10: While idle, `trial_code` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, honoured only while idle |
| cmp_hi | input | 1 | Comparator: 1 when the DAC level exceeds the input |
| trial_code | output | WIDTH | Code currently presented to the DAC |
| busy | output | 1 | High during the WIDTH bit cycles of a conversion |
| done | output | 1 | One-cycle pulse when `result` is written |
| result | output | WIDTH | Last completed conversion code |

## Verification
The bench builds two instances, one with the default WIDTH of 8 and one with WIDTH of 3. Both are driven by a behavioural DAC and comparator.

The 8-bit instance uses a 10 mV step. It covers the worked trial sequence for a 1 V input and every output code, using inputs half a step above each level. It also covers exact-equality inputs, full-scale overrange, and start pulses landing mid-conversion.

The 3-bit instance makes an exhaustive sweep of the inputs cheap. That sweep includes an overrange value, and it shows that the fixed length tracks the parameter.

// File: rtl/sar_ctrl_pkg.sv
// Package: shared types for the successive approximation controller.
// Assumes: nothing beyond standard SystemVerilog.
package sar_ctrl_pkg;

    // Controller phases: waiting for a request, or testing bits.
    typedef enum logic [0:0] {
        SAR_IDLE = 1'b0,
        SAR_RUN  = 1'b1
    } sar_phase_e;

endpackage

// File: rtl/sar_seq_fsm.sv
// Module: sar_seq_fsm
// Sequences one conversion: accepts a start while idle, then issues one step
// per clock until the bit pointer reports the last bit, then pulses done.
// Assumes: last_i is valid in every running cycle; reset is synchronous.
module sar_seq_fsm
    import sar_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o,
    output logic done_o
);

    sar_phase_e phase_q;
    sar_phase_e phase_d;
    logic       done_q;

    // Decode the control strobes from the current phase.
    always_comb begin
        load_o   = (phase_q == SAR_IDLE) && start_i;
        step_o   = (phase_q == SAR_RUN);
        finish_o = (phase_q == SAR_RUN) && last_i;
        busy_o   = (phase_q == SAR_RUN);
        done_o   = done_q;
    end

    // Compute the next phase; a start while running is not looked at.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            SAR_IDLE: if (start_i) phase_d = SAR_RUN;
            SAR_RUN:  if (last_i)  phase_d = SAR_IDLE;
            default:  phase_d = SAR_IDLE;
        endcase
    end

    // Register the phase and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SAR_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= finish_o;
        end
    end

endmodule

// File: rtl/sar_bit_ptr.sv
// Module: sar_bit_ptr
// One-hot pointer to the bit under test; starts at the MSB and walks down.
// Assumes: load and step are never high together.
module sar_bit_ptr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] ptr_o,
    output logic             last_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] ptr_q;

    // Load the MSB marker on start, shift it down one place per step.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (load_i) ptr_q <= TOP_BIT;
        else if (step_i) ptr_q <= ptr_q >> 1;
    end

    // Expose the pointer and flag the final bit.
    always_comb begin
        ptr_o  = ptr_q;
        last_o = ptr_q[0];
    end

endmodule

// File: rtl/sar_trial_reg.sv
// Module: sar_trial_reg
// The approximation register: per-bit keep/drop decisions and the result.
// Assumes: ptr_i is one-hot while step_i is high; cmp_hi_i is 1 when the
// DAC level for the current trial is above the input.
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             finish_i,
    input  logic [WIDTH-1:0] ptr_i,
    input  logic             cmp_hi_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o
);

    logic [WIDTH-1:0] trial_q;
    logic [WIDTH-1:0] settled;
    logic [WIDTH-1:0] next_ptr;
    logic [WIDTH-1:0] result_q;

    // Position of the bit that becomes the next trial.
    always_comb next_ptr = ptr_i >> 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Value of this bit once the current decision is applied.
        always_comb settled[i] = ptr_i[i] ? (trial_q[i] & ~cmp_hi_i) : trial_q[i];

        // Per-bit register: seed, decide, raise as next trial, or clear when idle.
        always_ff @(posedge clk) begin
            if (!rst_n)        trial_q[i] <= 1'b0;
            else if (load_i)   trial_q[i] <= (i == WIDTH - 1);
            else if (finish_i) trial_q[i] <= 1'b0;
            else if (step_i)   trial_q[i] <= settled[i] | next_ptr[i];
        end
    end

    // Capture the settled code once the final bit is decided.
    always_ff @(posedge clk) begin
        if (!rst_n)        result_q <= '0;
        else if (finish_i) result_q <= settled;
    end

    // Drive the outputs.
    always_comb begin
        trial_o  = trial_q;
        result_o = result_q;
    end

endmodule

// File: rtl/sar_approx_ctrl.sv
// Module: sar_approx_ctrl (top)
// Successive approximation control unit: one bit decision per clock, MSB
// first, fixed WIDTH-cycle conversion, one-cycle done with result update.
// Assumes: WIDTH >= 2; the comparator output settles within one clock of a
// trial code change.
module sar_approx_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_code,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);

    logic             load_s;
    logic             step_s;
    logic             finish_s;
    logic             last_s;
    logic [WIDTH-1:0] ptr_s;

    sar_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .last_i   (last_s),
        .load_o   (load_s),
        .step_o   (step_s),
        .finish_o (finish_s),
        .busy_o   (busy),
        .done_o   (done)
    );

    sar_bit_ptr #(.WIDTH(WIDTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_s),
        .step_i (step_s),
        .ptr_o  (ptr_s),
        .last_o (last_s)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_s),
        .step_i   (step_s),
        .finish_i (finish_s),
        .ptr_i    (ptr_s),
        .cmp_hi_i (cmp_hi),
        .trial_o  (trial_code),
        .result_o (result)
    );

endmodule

// File: rtl/sar_approx_ctrl_chk.sv
// Module: sar_approx_ctrl_chk
// Port-level protocol checks for sar_approx_ctrl, attached by bind.
// Assumes: same WIDTH as the bound instance.
module sar_approx_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cmp_hi,
    input logic [WIDTH-1:0] trial_code,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result
);

    localparam int CW = $clog2(WIDTH + 1) + 1;
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [CW-1:0] busy_run;

    // Count consecutive busy cycles to measure the conversion length.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r2_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && trial_code == TOP_BIT));

    // R6 and R8: a restart would stretch the count past WIDTH.
    a_r6_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_run == CW'(WIDTH)));

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CW'(WIDTH)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (trial_code == '0));

    // R3 and R4: the final bit decision matches the comparator.
    a_r3_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[0] == ($past(trial_code[0]) && !$past(cmp_hi))));

    a_r5_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[WIDTH-1:1] == $past(trial_code[WIDTH-1:1])));

endmodule

bind sar_approx_ctrl sar_approx_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmp_hi     (cmp_hi),
    .trial_code (trial_code),
    .busy       (busy),
    .done       (done),
    .result     (result)
);

// File: tb/sar_approx_ctrl_test.sv
// Bench: directed tests of sar_approx_ctrl at WIDTH 8 and WIDTH 3 with a
// behavioural DAC and comparator. Inputs change and outputs are read at
// the falling clock edge.
module sar_approx_ctrl_test;

    localparam int STEP_MV = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // 8-bit instance, input in millivolts
    logic       st8 = 1'b0;
    int         vin8 = 0;
    logic       cmp8;
    logic [7:0] tr8, res8;
    logic       busy8, done8;
    assign cmp8 = (int'(tr8) * STEP_MV) > vin8;

    sar_approx_ctrl #(.WIDTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(st8), .cmp_hi(cmp8),
        .trial_code(tr8), .busy(busy8), .done(done8), .result(res8)
    );

    // 3-bit instance, input in code units
    logic       st3 = 1'b0;
    int         vin3 = 0;
    logic       cmp3;
    logic [2:0] tr3, res3;
    logic       busy3, done3;
    assign cmp3 = int'(tr3) > vin3;

    sar_approx_ctrl #(.WIDTH(3)) uut_w3 (
        .clk(clk), .rst_n(rst_n), .start(st3), .cmp_hi(cmp3),
        .trial_code(tr3), .busy(busy3), .done(done3), .result(res3)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One 8-bit conversion; poke pulses start mid-run (R8).
    task automatic conv8(input int v, input bit poke, input string tag);
        int code = 0;
        int bad_trial = -1;
        int want_trial = -1;
        int t;
        vin8 = v;
        @(negedge clk); st8 = 1'b1;
        @(negedge clk); st8 = 1'b0;
        chk(busy8 && tr8 == 8'h80, {"R2 first trial ", tag}, int'(tr8), 128);
        for (int b = 7; b >= 0; b--) begin
            t = code | (1 << b);
            if ((int'(tr8) != t || !busy8) && bad_trial < 0) begin
                bad_trial = int'(tr8);
                want_trial = t;
            end
            if (!(t * STEP_MV > v)) code = t;
            if (poke && b == 4) st8 = 1'b1;
            @(negedge clk); st8 = 1'b0;
        end
        chk(bad_trial < 0, {"R5 trial sequence ", tag}, bad_trial, want_trial);
        chk(done8 && !busy8, {"R6 R7 done after 8 cycles ", tag}, {done8, busy8}, 2);
        chk(int'(res8) == code, {"R3 R4 result ", tag}, int'(res8), code);
        @(negedge clk);
        chk(!done8 && tr8 == 8'h00 && !busy8, {"R7 R10 pulse ends ", tag},
            {done8, busy8, tr8}, 0);
    endtask

    // One 3-bit conversion with an ideal comparator.
    task automatic conv3(input int v);
        int exp_code = (v > 7) ? 7 : v;
        vin3 = v;
        @(negedge clk); st3 = 1'b1;
        @(negedge clk); st3 = 1'b0;
        chk(busy3 && tr3 == 3'b100, "R2 first trial w3", int'(tr3), 4);
        repeat (2) begin
            @(negedge clk);
            chk(busy3 && !done3, "R6 still busy w3", {busy3, done3}, 2);
        end
        @(negedge clk);
        chk(done3 && !busy3 && int'(res3) == exp_code, "R6 R3 R4 result w3",
            int'(res3), exp_code);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!busy8 && !done8 && tr8 == 0 && res8 == 0, "R1 state in reset",
            {busy8, done8, tr8, res8}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy8 && !done8 && tr8 == 0 && res8 == 0 && !busy3, "R1 after reset",
            {busy8, done8, tr8, res8}, 0);
    endtask

    task automatic t_example();
        conv8(1000, 1'b0, "1V example");
        chk(res8 == 8'd100, "R4 equal keeps bit, 1V gives 100", int'(res8), 100);
    endtask

    task automatic t_boundaries();
        conv8(1280, 1'b0, "MSB equal");
        chk(res8 == 8'd128, "R4 MSB equality keeps", int'(res8), 128);
        conv8(1279, 1'b0, "below MSB");
        chk(res8 == 8'd127, "R3 MSB above clears", int'(res8), 127);
        conv8(0, 1'b0, "zero");
        conv8(5000, 1'b0, "overrange");
        chk(res8 == 8'd255, "R4 overrange saturates", int'(res8), 255);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 256; k++) conv8(k * STEP_MV + STEP_MV / 2, 1'b0, "sweep");
    endtask

    task automatic t_start_ignored();
        conv8(1730, 1'b1, "start while busy R8");
    endtask

    task automatic t_hold();
        logic [7:0] kept;
        conv8(420, 1'b0, "before hold");
        kept = res8;
        vin8 = 2000;
        repeat (6) begin
            @(negedge clk);
            chk(res8 == kept && tr8 == 0 && !busy8, "R9 R10 idle hold",
                int'(res8), int'(kept));
        end
    endtask

    task automatic t_width3();
        for (int v = 0; v < 9; v++) conv3(v);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_example();
        t_boundaries();
        t_start_ignored();
        t_hold();
        t_sweep();
        t_width3();
        finish_run();
    end

endmodule